// File: doc/BRIEF.md
# Auxiliary Activity Event Counter Bank

This block holds a parameterised set of 64-bit auxiliary activity counters. Each counter has its own enable and event input, and adds one in every cycle where both are high. Software reaches the counters through a register access port shaped like a system-register instruction. The port decodes the counter number from the encoded `op2` and `CRm` fields. Reads pass through a layered, privilege-dependent trap check. Writes are honoured only from the highest implemented privilege level.

Every accepted access gets a registered response one cycle later. The response carries one of three results: the read data, a trap with its target level and the fixed syndrome class, or an undefined-instruction indication. Counter numbers at or beyond the implemented count read as zero and ignore writes. A write that lands on a running counter is still carried out, and the response flags it.

Top module: `aux_evt_bank`

## Requirements
- R1: While `rst_ni` is low, every counter is cleared to zero and no response is produced.
- R2: An access is recognised only when op0=3, op1=3, CRn=13 and CRm[3:1]=3'b110. The counter number is {CRm[0], op2[2:0]}, so CRm[0] is bit 3 of the number. Any other encoding produces no response (`rsp_valid_o` stays 0) and changes no counter.
- R3: A recognised access presented at a clock edge raises `rsp_valid_o` for the following cycle. Read data is the counter value as it stood before that edge.
- R4: A counter adds one on every edge where its enable and event inputs are both 1. It does not change while disabled. From all ones it wraps to zero.
- R5: A read from level 0 with `user_en_i`=0 traps. The target is level 2 when level 2 is on and `host_mode_i`=1, and level 1 otherwise. This check comes before all others.
- R6: If no earlier check traps a read from level 0 or level 1, `lvl2_trap_i`=1 with level 2 on sends it to level 2. Failing that, `lvl3_trap_i`=1 sends it to level 3. A level-2 read traps to level 3 only when `lvl3_trap_i`=1. A level-3 read never traps.
- R7: A trapped read sets `rsp_trap_o`=1, gives the target level on `rsp_trap_lvl_o` (2-bit level number), reports `rsp_class_o`=0x18 and returns zero data. Untrapped responses report class 0.
- R8: A write is performed only when `cur_lvl_i` equals the highest implemented level (3 by default). Trap bits do not apply to writes. A write from any other level sets `rsp_undef_o`=1 and leaves the counter unchanged.
- R9: A counter number at or above `NUM_CNT` reads as zero and ignores writes, without disturbing any implemented counter.
- R10: A write to an enabled counter is performed and sets `rsp_wr_busy_o`=1. It takes precedence over an event in the same cycle. A write to a disabled counter leaves `rsp_wr_busy_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low cold reset |
| cnt_en_i | input | NUM_CNT | Per-counter enable |
| evt_i | input | NUM_CNT | Per-counter event pulse |
| acc_valid_i | input | 1 | Access request |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_op0_i | input | 2 | Encoded op0 field |
| acc_op1_i | input | 3 | Encoded op1 field |
| acc_crn_i | input | 4 | Encoded CRn field |
| acc_crm_i | input | 4 | Encoded CRm field |
| acc_op2_i | input | 3 | Encoded op2 field |
| acc_wdata_i | input | CNT_W | Write data |
| cur_lvl_i | input | 2 | Current privilege level |
| user_en_i | input | 1 | Lowest-level access enable |
| lvl2_on_i | input | 1 | Level 2 enabled |
| host_mode_i | input | 1 | Level 2 host mode |
| lvl2_trap_i | input | 1 | Level 2 counter trap bit |
| lvl3_trap_i | input | 1 | Level 3 counter trap bit |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | CNT_W | Read data |
| rsp_trap_o | output | 1 | Access trapped |
| rsp_trap_lvl_o | output | 2 | Trap target level |
| rsp_class_o | output | 6 | Syndrome class |
| rsp_undef_o | output | 1 | Undefined-instruction indication |
| rsp_wr_busy_o | output | 1 | Write hit an enabled counter |

## Verification
The bench walks the trap cascade across all four levels. It targets the orderings that are easy to get wrong: the user-enable check must win over the level-2 bit, the level-2 bit must count only when level 2 is on, and a level-3 read must ignore every bit. A design with the checks in the wrong order would report the wrong target level. A design that ignored level-2 enablement would trap to level 2 where level 3 is expected.

Numbers 8 and 11 are written to confirm that CRm[0] feeds bit 3. A decoder that dropped that bit would alias them onto counters 0 and 3 and corrupt the stored values.

The bench also checks the wrap from all ones and a write that lands on an enabled counter during an event. A design that let the increment win would read back one more than the value written.

// File: rtl/aux_evt_pkg.sv
package aux_evt_pkg;

   localparam int MAX_CNT  = 16;
   localparam int IDX_W    = 4;
   localparam int CLASS_W  = 6;
   localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

   typedef logic [1:0] lvl_t;

   typedef struct packed {
      logic trap;
      lvl_t lvl;
   } trap_res_t;

   function automatic lvl_t top_level(input bit has_l2, input bit has_l3);
      if (has_l3)      return 2'd3;
      else if (has_l2) return 2'd2;
      else             return 2'd1;
   endfunction

endpackage

// File: rtl/aux_evt_sel_dec.sv
module aux_evt_sel_dec
   import aux_evt_pkg::*;
(
   input  logic [1:0]       op0_i,
   input  logic [2:0]       op1_i,
   input  logic [3:0]       crn_i,
   input  logic [3:0]       crm_i,
   input  logic [2:0]       op2_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [1:0] OP0_K   = 2'b11;
   localparam logic [2:0] OP1_K   = 3'b011;
   localparam logic [3:0] CRN_K   = 4'b1101;
   localparam logic [2:0] CRM_HI  = 3'b110;

   always_comb begin
      hit_o = (op0_i == OP0_K) && (op1_i == OP1_K) &&
              (crn_i == CRN_K) && (crm_i[3:1] == CRM_HI);
      idx_o = {crm_i[0], op2_i};
   end

endmodule

// File: rtl/aux_evt_trap.sv
module aux_evt_trap
   import aux_evt_pkg::*;
#(
   parameter bit HAS_L2 = 1'b1,
   parameter bit HAS_L3 = 1'b1
)(
   input  lvl_t      lvl_i,
   input  logic      user_en_i,
   input  logic      l2_on_i,
   input  logic      host_i,
   input  logic      l2_trap_i,
   input  logic      l3_trap_i,
   output trap_res_t res_o
);

   logic l2_live;
   logic l2_hit;
   logic l3_hit;

   generate
      if (HAS_L2) begin : g_l2
         assign l2_live = l2_on_i;
      end else begin : g_no_l2
         assign l2_live = 1'b0;
      end
      if (HAS_L3) begin : g_l3
         assign l3_hit = l3_trap_i;
      end else begin : g_no_l3
         assign l3_hit = 1'b0;
      end
   endgenerate

   assign l2_hit = l2_live & l2_trap_i;

   always_comb begin
      res_o = '{trap: 1'b0, lvl: 2'd0};
      unique case (lvl_i)
         2'd0: begin
            if (!user_en_i)
               res_o = '{trap: 1'b1, lvl: (l2_live && host_i) ? 2'd2 : 2'd1};
            else if (l2_hit)
               res_o = '{trap: 1'b1, lvl: 2'd2};
            else if (l3_hit)
               res_o = '{trap: 1'b1, lvl: 2'd3};
         end
         2'd1: begin
            if (l2_hit)
               res_o = '{trap: 1'b1, lvl: 2'd2};
            else if (l3_hit)
               res_o = '{trap: 1'b1, lvl: 2'd3};
         end
         2'd2: begin
            if (l3_hit)
               res_o = '{trap: 1'b1, lvl: 2'd3};
         end
         default: res_o = '{trap: 1'b0, lvl: 2'd0};
      endcase
   end

endmodule

// File: rtl/aux_evt_ctr.sv
module aux_evt_ctr #(
   parameter int CNT_W = 64
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             evt_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] val_o
);

   logic [CNT_W-1:0] val_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         val_q <= '0;
      else if (wr_i)
         val_q <= wdata_i;
      else if (en_i && evt_i)
         val_q <= val_q + CNT_W'(1);
   end

   assign val_o = val_q;

endmodule

// File: rtl/aux_evt_bank.sv
module aux_evt_bank
   import aux_evt_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 64,
   parameter bit HAS_L2  = 1'b1,
   parameter bit HAS_L3  = 1'b1
)(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_CNT-1:0] cnt_en_i,
   input  logic [NUM_CNT-1:0] evt_i,
   input  logic               acc_valid_i,
   input  logic               acc_write_i,
   input  logic [1:0]         acc_op0_i,
   input  logic [2:0]         acc_op1_i,
   input  logic [3:0]         acc_crn_i,
   input  logic [3:0]         acc_crm_i,
   input  logic [2:0]         acc_op2_i,
   input  logic [CNT_W-1:0]   acc_wdata_i,
   input  logic [1:0]         cur_lvl_i,
   input  logic               user_en_i,
   input  logic               lvl2_on_i,
   input  logic               host_mode_i,
   input  logic               lvl2_trap_i,
   input  logic               lvl3_trap_i,
   output logic               rsp_valid_o,
   output logic [CNT_W-1:0]   rsp_rdata_o,
   output logic               rsp_trap_o,
   output logic [1:0]         rsp_trap_lvl_o,
   output logic [5:0]         rsp_class_o,
   output logic               rsp_undef_o,
   output logic               rsp_wr_busy_o
);

   localparam lvl_t TOP_LVL = top_level(HAS_L2, HAS_L3);

   generate
      if (NUM_CNT < 1 || NUM_CNT > MAX_CNT) begin : g_bad_num
         $error("aux_evt_bank: NUM_CNT must lie in 1..16");
      end
      if (CNT_W < 2) begin : g_bad_width
         $error("aux_evt_bank: CNT_W must be at least 2");
      end
   endgenerate

   logic             dec_hit;
   logic [IDX_W-1:0] dec_idx;
   trap_res_t        trap_res;

   aux_evt_sel_dec i_dec (
      .op0_i (acc_op0_i),
      .op1_i (acc_op1_i),
      .crn_i (acc_crn_i),
      .crm_i (acc_crm_i),
      .op2_i (acc_op2_i),
      .hit_o (dec_hit),
      .idx_o (dec_idx)
   );

   aux_evt_trap #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) i_trap (
      .lvl_i     (cur_lvl_i),
      .user_en_i (user_en_i),
      .l2_on_i   (lvl2_on_i),
      .host_i    (host_mode_i),
      .l2_trap_i (lvl2_trap_i),
      .l3_trap_i (lvl3_trap_i),
      .res_o     (trap_res)
   );

   logic acc_hit, acc_rd, acc_wr, wr_allowed, wr_go, rd_ok;
   assign acc_hit    = acc_valid_i & dec_hit;
   assign acc_rd     = acc_hit & ~acc_write_i;
   assign acc_wr     = acc_hit & acc_write_i;
   assign wr_allowed = (cur_lvl_i == TOP_LVL);
   assign wr_go      = acc_wr & wr_allowed;
   assign rd_ok      = acc_rd & ~trap_res.trap;

   logic [NUM_CNT-1:0] wr_sel;
   logic [CNT_W-1:0]   cnt_val [NUM_CNT];

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      assign wr_sel[k] = wr_go & (dec_idx == IDX_W'(k));
      aux_evt_ctr #(.CNT_W(CNT_W)) i_ctr (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .en_i    (cnt_en_i[k]),
         .evt_i   (evt_i[k]),
         .wr_i    (wr_sel[k]),
         .wdata_i (acc_wdata_i),
         .val_o   (cnt_val[k])
      );
   end

   logic [CNT_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NUM_CNT; k++)
         if (dec_idx == IDX_W'(k))
            rd_mux = cnt_val[k];
   end

   logic             valid_q, trap_q, undef_q, busy_q;
   lvl_t             lvl_q;
   logic [CNT_W-1:0] rdata_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         trap_q  <= 1'b0;
         lvl_q   <= 2'd0;
         undef_q <= 1'b0;
         busy_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         valid_q <= acc_hit;
         trap_q  <= acc_rd & trap_res.trap;
         lvl_q   <= (acc_rd & trap_res.trap) ? trap_res.lvl : 2'd0;
         undef_q <= acc_wr & ~wr_allowed;
         busy_q  <= |(wr_sel & cnt_en_i);
         rdata_q <= rd_ok ? rd_mux : '0;
      end
   end

   assign rsp_valid_o    = valid_q;
   assign rsp_rdata_o    = rdata_q;
   assign rsp_trap_o     = trap_q;
   assign rsp_trap_lvl_o = lvl_q;
   assign rsp_class_o    = trap_q ? TRAP_CLASS : '0;
   assign rsp_undef_o    = undef_q;
   assign rsp_wr_busy_o  = busy_q;

endmodule

// File: rtl/aux_evt_bank_chk.sv
module aux_evt_bank_chk #(
   parameter int         CNT_W   = 64,
   parameter logic [1:0] TOP_LVL = 2'd3
)(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             acc_valid_i,
   input logic             acc_write_i,
   input logic [1:0]       acc_op0_i,
   input logic [2:0]       acc_op1_i,
   input logic [3:0]       acc_crn_i,
   input logic [3:0]       acc_crm_i,
   input logic [1:0]       cur_lvl_i,
   input logic             lvl3_trap_i,
   input logic             rsp_valid_o,
   input logic [CNT_W-1:0] rsp_rdata_o,
   input logic             rsp_trap_o,
   input logic [1:0]       rsp_trap_lvl_o,
   input logic [5:0]       rsp_class_o,
   input logic             rsp_undef_o
);

   logic seen;
   assign seen = acc_valid_i && acc_op0_i == 2'b11 && acc_op1_i == 3'b011 &&
                 acc_crn_i == 4'b1101 && acc_crm_i[3:1] == 3'b110;

   assert_no_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen |=> !rsp_valid_o);

   assert_rsp_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |=> rsp_valid_o);

   assert_top_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && !acc_write_i && cur_lvl_i == 2'd3) |=> !rsp_trap_o);

   assert_l2_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && !acc_write_i && cur_lvl_i == 2'd2 && !lvl3_trap_i) |=> !rsp_trap_o);

   assert_trap_upward_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_trap_o |-> rsp_trap_lvl_o > $past(cur_lvl_i));

   assert_trap_class_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_trap_o |-> (rsp_class_o == 6'h18 && rsp_rdata_o == '0));

   assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rsp_trap_o && rsp_undef_o));

   assert_low_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && acc_write_i && cur_lvl_i != TOP_LVL) |=> (rsp_undef_o && rsp_rdata_o == '0));

endmodule

bind aux_evt_bank aux_evt_bank_chk #(.CNT_W(CNT_W), .TOP_LVL(TOP_LVL)) i_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .acc_valid_i    (acc_valid_i),
   .acc_write_i    (acc_write_i),
   .acc_op0_i      (acc_op0_i),
   .acc_op1_i      (acc_op1_i),
   .acc_crn_i      (acc_crn_i),
   .acc_crm_i      (acc_crm_i),
   .cur_lvl_i      (cur_lvl_i),
   .lvl3_trap_i    (lvl3_trap_i),
   .rsp_valid_o    (rsp_valid_o),
   .rsp_rdata_o    (rsp_rdata_o),
   .rsp_trap_o     (rsp_trap_o),
   .rsp_trap_lvl_o (rsp_trap_lvl_o),
   .rsp_class_o    (rsp_class_o),
   .rsp_undef_o    (rsp_undef_o)
);

// File: tb/test_aux_evt_bank.sv
`timescale 1ns/1ps
module test_aux_evt_bank;

   localparam int NC = 4;
   localparam int CW = 64;

   // {lvl[1:0], user_en, l2_on, host, l2_trap, l3_trap, exp_trap, exp_lvl[1:0]}
   localparam logic [9:0] VEC [12] = '{
      10'b00_0_1_1_0_0_1_10,
      10'b00_0_0_1_0_0_1_01,
      10'b00_0_1_0_1_0_1_01,
      10'b00_1_1_0_1_0_1_10,
      10'b00_1_0_0_1_1_1_11,
      10'b00_1_0_0_0_0_0_00,
      10'b01_0_0_0_0_0_0_00,
      10'b01_1_1_0_1_1_1_10,
      10'b01_1_0_0_0_1_1_11,
      10'b10_1_1_0_1_0_0_00,
      10'b10_1_0_0_0_1_1_11,
      10'b11_0_1_1_1_1_0_00
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NC-1:0] cnt_en, evt;
   logic          acc_valid, acc_write;
   logic [1:0]    op0;
   logic [2:0]    op1, op2;
   logic [3:0]    crn, crm;
   logic [CW-1:0] wdata;
   logic [1:0]    cur_lvl;
   logic          user_en, l2_on, host, l2_trap, l3_trap;
   logic          rsp_valid, rsp_trap, rsp_undef, rsp_busy;
   logic [CW-1:0] rsp_rdata;
   logic [1:0]    rsp_lvl;
   logic [5:0]    rsp_class;

   aux_evt_bank #(.NUM_CNT(NC), .CNT_W(CW)) i_aux_evt_bank (
      .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .evt_i(evt),
      .acc_valid_i(acc_valid), .acc_write_i(acc_write),
      .acc_op0_i(op0), .acc_op1_i(op1), .acc_crn_i(crn), .acc_crm_i(crm),
      .acc_op2_i(op2), .acc_wdata_i(wdata), .cur_lvl_i(cur_lvl),
      .user_en_i(user_en), .lvl2_on_i(l2_on), .host_mode_i(host),
      .lvl2_trap_i(l2_trap), .lvl3_trap_i(l3_trap),
      .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_trap_o(rsp_trap),
      .rsp_trap_lvl_o(rsp_lvl), .rsp_class_o(rsp_class),
      .rsp_undef_o(rsp_undef), .rsp_wr_busy_o(rsp_busy)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put(input bit wr, input logic [3:0] idx, input logic [1:0] lvl,
                      input logic [CW-1:0] wd);
      acc_valid = 1'b1; acc_write = wr;
      op0 = 2'b11; op1 = 3'b011; crn = 4'b1101;
      crm = {3'b110, idx[3]}; op2 = idx[2:0];
      cur_lvl = lvl; wdata = wd;
   endtask

   task automatic acc(input bit wr, input logic [3:0] idx, input logic [1:0] lvl,
                      input logic [CW-1:0] wd);
      @(negedge clk);
      put(wr, idx, lvl, wd);
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic open_ctl();
      user_en = 1'b1; l2_on = 1'b0; host = 1'b0; l2_trap = 1'b0; l3_trap = 1'b0;
   endtask

   localparam logic [CW-1:0] C0 = 64'h0123_4567_89AB_CDEF;

   initial begin
      cnt_en = '0; evt = '0; acc_valid = 1'b0; acc_write = 1'b0;
      op0 = '0; op1 = '0; op2 = '0; crn = '0; crm = '0; wdata = '0; cur_lvl = '0;
      open_ctl();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle no response", 64'(rsp_valid), 64'd0);

      for (int k = 0; k < NC; k++) begin
         acc(1'b0, 4'(k), 2'd3, '0);
         chk("R1 counter reset value", rsp_rdata, 64'd0);
         chk("R3 response valid", 64'(rsp_valid), 64'd1);
      end

      acc(1'b1, 4'd0, 2'd3, C0);
      chk("R10 write to idle counter not busy", 64'(rsp_busy), 64'd0);
      chk("R8 top-level write defined", 64'(rsp_undef), 64'd0);

      for (int i = 0; i < 12; i++) begin
         logic [9:0] v;
         string      tag;
         v = VEC[i];
         user_en = v[7]; l2_on = v[6]; host = v[5]; l2_trap = v[4]; l3_trap = v[3];
         tag = (v[9:8] == 2'd0 && !v[7]) ? "R5 trap cascade" : "R6 trap cascade";
         acc(1'b0, 4'd0, v[9:8], '0);
         chk(tag, {61'd0, rsp_trap, rsp_lvl}, {61'd0, v[2:0]});
         if (v[2]) begin
            chk("R7 trap class", 64'(rsp_class), 64'h18);
            chk("R7 trap data zero", rsp_rdata, 64'd0);
         end else begin
            chk("R7 no-trap class", 64'(rsp_class), 64'd0);
            chk("R3 read data", rsp_rdata, C0);
         end
      end
      open_ctl();

      acc(1'b1, 4'd3, 2'd3, 64'h3333);
      acc(1'b1, 4'd11, 2'd3, 64'hDEAD);
      acc(1'b1, 4'd8, 2'd3, 64'hBEEF);
      acc(1'b0, 4'd3, 2'd3, '0);
      chk("R2 counter number bit 3", rsp_rdata, 64'h3333);
      acc(1'b0, 4'd0, 2'd3, '0);
      chk("R9 out-of-range write ignored", rsp_rdata, C0);
      acc(1'b0, 4'd11, 2'd3, '0);
      chk("R9 out-of-range reads zero", rsp_rdata, 64'd0);
      chk("R9 out-of-range not trapped", 64'(rsp_trap), 64'd0);

      @(negedge clk);
      put(1'b1, 4'd0, 2'd3, 64'h55);
      crn = 4'b1100;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
      chk("R2 foreign encoding no response", 64'(rsp_valid), 64'd0);
      acc(1'b0, 4'd0, 2'd3, '0);
      chk("R2 foreign encoding no write", rsp_rdata, C0);

      acc(1'b1, 4'd1, 2'd2, 64'h77);
      chk("R8 low-level write undefined", 64'(rsp_undef), 64'd1);
      acc(1'b0, 4'd1, 2'd3, '0);
      chk("R8 low-level write dropped", rsp_rdata, 64'd0);
      user_en = 1'b0; l3_trap = 1'b1;
      acc(1'b1, 4'd1, 2'd3, 64'h77);
      chk("R8 trap bits skip writes", 64'(rsp_trap | rsp_undef), 64'd0);
      open_ctl();
      acc(1'b0, 4'd1, 2'd3, '0);
      chk("R8 top-level write stored", rsp_rdata, 64'h77);

      @(negedge clk); evt[2] = 1'b1;
      repeat (3) @(negedge clk);
      begin
         logic [7:0] pat;
         pat = 8'b1011_0101;
         for (int i = 0; i < 8; i++) begin
            cnt_en[2] = 1'b1; evt[2] = pat[i];
            @(negedge clk);
         end
         cnt_en[2] = 1'b0; evt[2] = 1'b0;
      end
      acc(1'b0, 4'd2, 2'd3, '0);
      chk("R4 counts enabled events", rsp_rdata, 64'd5);

      acc(1'b1, 4'd2, 2'd3, '1);
      @(negedge clk); cnt_en[2] = 1'b1; evt[2] = 1'b1;
      @(negedge clk); cnt_en[2] = 1'b0; evt[2] = 1'b0;
      acc(1'b0, 4'd2, 2'd3, '0);
      chk("R4 wrap to zero", rsp_rdata, 64'd0);

      @(negedge clk);
      cnt_en[3] = 1'b1; evt[3] = 1'b1;
      put(1'b1, 4'd3, 2'd3, 64'h4000);
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; cnt_en[3] = 1'b0; evt[3] = 1'b0;
      chk("R10 busy flag", 64'(rsp_busy), 64'd1);
      acc(1'b0, 4'd3, 2'd3, '0);
      chk("R10 write beats event", rsp_rdata, 64'h4000);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule